// File: doc/BRIEF.md
# Seed-Extension Alignment Array

This block scores how well a short query read extends against a piece of reference sequence. It is a linear systolic array with one processing element (PE) per query symbol. Before a job starts, the query is loaded in parallel. Reference symbols then stream in one per cycle. Each accepted reference symbol walks down the array one PE per cycle, and every PE it visits computes one cell of the similarity matrix. Rows of the matrix are reference positions and columns are query positions.

Two scoring modes exist. In local mode the matrix border is zero and no cell falls below zero. In extension mode the corner of the border holds a seed score given at launch, and the border drops by the gap cost for each step away from that corner. When the final PE has handled the last row, the block pulses `done`. At that point it presents the best score found anywhere in the active columns and the best score found in the final query column, each with its row and column.

Top module: `seed_ext_array`

## Requirements
- R1: A `start` pulse while the array is idle captures the mode (`start_mode` 1 = extension, 0 = local), the seed, the query length (1..NUM_PE) and the query. A `start` pulse while a job is in progress has no effect.
- R2: In local mode every border cell is 0 and every computed cell is floored at 0.
- R3: In extension mode the border cell k steps from the corner holds seed − k·GAP, with the corner itself holding the seed. Computed cells are not floored.
- R4: Each cell is the maximum of three candidates: the diagonal neighbour plus MATCH (equal symbols) or MISMATCH (unequal symbols), the left neighbour minus GAP, and the upper neighbour minus GAP. Symbols use the 2-bit codes A=0, C=1, G=2 and T=3.
- R5: Scores are SW-bit two's-complement values that saturate at the most positive and most negative values instead of wrapping.
- R6: `best_score`, `best_row` and `best_col` give the highest cell over rows 0..(reference length − 1) and columns 0..(query length − 1), with rows and columns 0-based. On a tie the smaller column wins, and within a column the smaller row wins.
- R7: `end_score`, `end_row` and `end_col` give the highest cell in column (query length − 1), with the earliest row winning a tie.
- R8: `done` is a one-cycle pulse that rises exactly NUM_PE cycles after the cycle in which the reference symbol flagged `ref_last` is accepted. Each accepted symbol reaches PE c exactly c cycles after acceptance. The result outputs hold their values until the next `done`.
- R9: `ref_ready` is high from the cycle after an accepted `start` until the `ref_last` symbol is accepted, and low at all other times. Symbols offered while `ref_ready` is low are ignored.
- R10: Query symbol c sits at bits [2c+1:2c] of `query_syms`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse, taken only when idle |
| start_mode | input | 1 | 1 = extension mode, 0 = local mode |
| start_seed | input | SW | Signed seed score used in extension mode |
| start_qlen | input | clog2(NUM_PE+1) | Query length, 1..NUM_PE |
| query_syms | input | 2·NUM_PE | Packed query symbols, column c at [2c+1:2c] |
| ref_valid | input | 1 | Reference symbol offered |
| ref_ready | output | 1 | Array accepts a reference symbol |
| ref_sym | input | 2 | Reference symbol code |
| ref_last | input | 1 | Marks the final reference symbol |
| done | output | 1 | One-cycle result strobe |
| best_score | output | SW | Best cell score in the active columns |
| best_row | output | ROW_W | Row of the best cell |
| best_col | output | clog2(NUM_PE) | Column of the best cell |
| end_score | output | SW | Best score in the final query column |
| end_row | output | ROW_W | Row of that score |
| end_col | output | clog2(NUM_PE) | Final query column |

## Verification
The assertions assume the following about the inputs:
- Every accepted `start` carries a query length between 1 and NUM_PE.
- The reference stream of each job ends with a `ref_last` symbol.
- The reference is short enough that the row counter does not wrap.

The stimulus keeps within these limits as follows:
- It draws query lengths only from 1..NUM_PE.
- It keeps references to at most a few dozen symbols.
- It always flags the final symbol.
- It withdraws `ref_valid` before launching a new job, so any symbol offered while idle is never taken by mistake.

// File: rtl/sxa_pkg.sv
package sxa_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } sxa_state_e;

    typedef logic [1:0] sxa_sym_t;

    // Clamp an integer into the range of an sw-bit two's-complement value.
    function automatic int sxa_clamp(input int v, input int sw);
        int hi;
        int lo;
        hi = (1 << (sw - 1)) - 1;
        lo = -(1 << (sw - 1));
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

endpackage

// File: rtl/sxa_ctrl.sv
module sxa_ctrl
    import sxa_pkg::*;
#(
    parameter int NUM_PE = 16,
    parameter int SW     = 16,
    parameter int ROW_W  = 16,
    parameter int GAP    = 1,
    localparam int CNT_W  = (NUM_PE > 1) ? $clog2(NUM_PE) : 1,
    localparam int QLEN_W = $clog2(NUM_PE + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 start_mode,
    input  logic signed [SW-1:0] start_seed,
    input  logic [QLEN_W-1:0]    start_qlen,
    input  logic                 ref_valid,
    input  sxa_sym_t             ref_sym,
    input  logic                 ref_last,
    output logic                 ref_ready,
    output logic                 load,
    output logic                 mode_local,
    output logic [QLEN_W-1:0]    qlen,
    output logic                 pe0_valid,
    output sxa_sym_t             pe0_sym,
    output logic [ROW_W-1:0]     pe0_row,
    output logic signed [SW-1:0] pe0_left,
    output logic signed [SW-1:0] pe0_diag,
    output logic                 fin
);

    typedef struct packed {
        sxa_state_e              st;
        logic [CNT_W-1:0]        cnt;
        logic [ROW_W-1:0]        row;
        logic signed [SW-1:0]    lb;     // left border of the previous row
        logic                    loc;
        logic [QLEN_W-1:0]       qlen;
    } ctrl_s;

    ctrl_s ctrl_d, ctrl_q;
    logic  accept;
    logic signed [SW-1:0] lb_next;

    always_comb begin : ctrl_next
        ctrl_d  = ctrl_q;
        fin     = 1'b0;
        accept  = (ctrl_q.st == ST_RUN) && ref_valid;
        lb_next = ctrl_q.loc ? '0 : SW'(sxa_clamp(int'(ctrl_q.lb) - GAP, SW));
        case (ctrl_q.st)
            ST_IDLE: begin
                if (start) begin
                    ctrl_d.st   = ST_RUN;
                    ctrl_d.row  = '0;
                    ctrl_d.loc  = !start_mode;
                    ctrl_d.lb   = start_mode ? start_seed : '0;
                    ctrl_d.qlen = start_qlen;
                end
            end
            ST_RUN: begin
                if (ref_valid) begin
                    ctrl_d.row = ctrl_q.row + 1'b1;
                    ctrl_d.lb  = lb_next;
                    if (ref_last) begin
                        ctrl_d.st  = ST_DRAIN;
                        ctrl_d.cnt = '0;
                    end
                end
            end
            ST_DRAIN: begin
                if (ctrl_q.cnt == CNT_W'(NUM_PE - 1)) begin
                    ctrl_d.st = ST_IDLE;
                    fin       = 1'b1;
                end else begin
                    ctrl_d.cnt = ctrl_q.cnt + 1'b1;
                end
            end
            default: ctrl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '{st: ST_IDLE, cnt: '0, row: '0, lb: '0, loc: 1'b1, qlen: '0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign ref_ready  = (ctrl_q.st == ST_RUN);
    assign load       = (ctrl_q.st == ST_IDLE) && start;
    assign mode_local = ctrl_q.loc;
    assign qlen       = ctrl_q.qlen;
    assign pe0_valid  = accept;
    assign pe0_sym    = ref_sym;
    assign pe0_row    = ctrl_q.row;
    assign pe0_diag   = ctrl_q.lb;
    assign pe0_left   = lb_next;

    AST_QLEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (start_qlen >= QLEN_W'(1) && start_qlen <= QLEN_W'(NUM_PE))); // R1

    AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_ready && ref_valid && ref_last) |=> !ref_ready); // R9

endmodule

// File: rtl/sxa_pe.sv
module sxa_pe
    import sxa_pkg::*;
#(
    parameter int SW       = 16,
    parameter int ROW_W    = 16,
    parameter int MATCH    = 2,
    parameter int MISMATCH = -1,
    parameter int GAP      = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  sxa_sym_t             load_sym,
    input  logic signed [SW-1:0] load_top,
    input  logic                 mode_local,
    input  logic                 in_valid,
    input  sxa_sym_t             in_sym,
    input  logic [ROW_W-1:0]     in_row,
    input  logic signed [SW-1:0] in_left,
    input  logic signed [SW-1:0] in_diag,
    output logic                 out_valid,
    output sxa_sym_t             out_sym,
    output logic [ROW_W-1:0]     out_row,
    output logic signed [SW-1:0] out_h,
    output logic signed [SW-1:0] out_hdiag,
    output logic signed [SW-1:0] best_score,
    output logic [ROW_W-1:0]     best_row
);

    localparam int MINV = -(1 << (SW - 1));

    typedef struct packed {
        sxa_sym_t             qsym;
        logic signed [SW-1:0] h;      // cell of the latest row in this column
        logic signed [SW-1:0] hdiag;  // cell of the row before it
        logic                 fv;
        sxa_sym_t             fsym;
        logic [ROW_W-1:0]     frow;
        logic signed [SW-1:0] best;
        logic [ROW_W-1:0]     brow;
    } pe_s;

    pe_s pe_d, pe_q;
    logic signed [SW-1:0] cand;

    always_comb begin : pe_next
        int dg;
        int lf;
        int up;
        int m;
        dg = int'(in_diag) + ((in_sym == pe_q.qsym) ? MATCH : MISMATCH);
        lf = int'(in_left) - GAP;
        up = int'(pe_q.h) - GAP;
        m  = dg;
        if (lf > m) m = lf;
        if (up > m) m = up;
        if (mode_local && m < 0) m = 0;
        cand = SW'(sxa_clamp(m, SW));

        pe_d    = pe_q;
        pe_d.fv = in_valid && !load;
        if (load) begin
            pe_d.qsym  = load_sym;
            pe_d.h     = load_top;
            pe_d.hdiag = load_top;
            pe_d.best  = SW'(MINV);
            pe_d.brow  = '0;
        end else if (in_valid) begin
            pe_d.h     = cand;
            pe_d.hdiag = pe_q.h;
            pe_d.fsym  = in_sym;
            pe_d.frow  = in_row;
            if (cand > pe_q.best) begin
                pe_d.best = cand;
                pe_d.brow = in_row;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pe_q <= '{qsym: '0, h: '0, hdiag: '0, fv: 1'b0, fsym: '0,
                      frow: '0, best: '0, brow: '0};
        end else begin
            pe_q <= pe_d;
        end
    end

    assign out_valid  = pe_q.fv;
    assign out_sym    = pe_q.fsym;
    assign out_row    = pe_q.frow;
    assign out_h      = pe_q.h;
    assign out_hdiag  = pe_q.hdiag;
    assign best_score = pe_q.best;
    assign best_row   = pe_q.brow;

    AST_BEST_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !load) |=> (best_score >= $past(best_score))); // R6

endmodule

// File: rtl/sxa_pick.sv
module sxa_pick #(
    parameter int NUM_PE = 16,
    parameter int SW     = 16,
    parameter int ROW_W  = 16,
    localparam int COL_W  = (NUM_PE > 1) ? $clog2(NUM_PE) : 1,
    localparam int QLEN_W = $clog2(NUM_PE + 1)
) (
    input  logic [NUM_PE-1:0][SW-1:0]    pe_best,
    input  logic [NUM_PE-1:0][ROW_W-1:0] pe_brow,
    input  logic [QLEN_W-1:0]            qlen,
    output logic signed [SW-1:0]         sel_score,
    output logic [ROW_W-1:0]             sel_row,
    output logic [COL_W-1:0]             sel_col,
    output logic signed [SW-1:0]         end_score,
    output logic [ROW_W-1:0]             end_row,
    output logic [COL_W-1:0]             end_col
);

    always_comb begin : pick_best
        sel_score = pe_best[0];
        sel_row   = pe_brow[0];
        sel_col   = '0;
        for (int c = 1; c < NUM_PE; c++) begin
            if (c < int'(qlen) && $signed(pe_best[c]) > sel_score) begin
                sel_score = pe_best[c];
                sel_row   = pe_brow[c];
                sel_col   = COL_W'(c);
            end
        end
        end_col   = COL_W'(int'(qlen) - 1);
        end_score = pe_best[end_col];
        end_row   = pe_brow[end_col];
    end

endmodule

// File: rtl/seed_ext_array.sv
module seed_ext_array
    import sxa_pkg::*;
#(
    parameter int NUM_PE   = 16,
    parameter int SW       = 16,
    parameter int ROW_W    = 16,
    parameter int MATCH    = 2,
    parameter int MISMATCH = -1,
    parameter int GAP      = 1,
    localparam int COL_W  = (NUM_PE > 1) ? $clog2(NUM_PE) : 1,
    localparam int QLEN_W = $clog2(NUM_PE + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  start_mode,
    input  logic signed [SW-1:0]  start_seed,
    input  logic [QLEN_W-1:0]     start_qlen,
    input  logic [2*NUM_PE-1:0]   query_syms,
    input  logic                  ref_valid,
    output logic                  ref_ready,
    input  logic [1:0]            ref_sym,
    input  logic                  ref_last,
    output logic                  done,
    output logic signed [SW-1:0]  best_score,
    output logic [ROW_W-1:0]      best_row,
    output logic [COL_W-1:0]      best_col,
    output logic signed [SW-1:0]  end_score,
    output logic [ROW_W-1:0]      end_row,
    output logic [COL_W-1:0]      end_col
);

    logic                  load;
    logic                  mode_local;
    logic [QLEN_W-1:0]     qlen;
    logic                  fin;

    logic [NUM_PE:0]              ch_valid;
    logic [NUM_PE:0][1:0]         ch_sym;
    logic [NUM_PE:0][ROW_W-1:0]   ch_row;
    logic [NUM_PE:0][SW-1:0]      ch_h;
    logic [NUM_PE:0][SW-1:0]      ch_hdiag;
    logic [NUM_PE-1:0][SW-1:0]    pe_best;
    logic [NUM_PE-1:0][ROW_W-1:0] pe_brow;

    logic signed [SW-1:0]  pk_score;
    logic [ROW_W-1:0]      pk_row;
    logic [COL_W-1:0]      pk_col;
    logic signed [SW-1:0]  pk_escore;
    logic [ROW_W-1:0]      pk_erow;
    logic [COL_W-1:0]      pk_ecol;

    sxa_ctrl #(
        .NUM_PE (NUM_PE),
        .SW     (SW),
        .ROW_W  (ROW_W),
        .GAP    (GAP)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_mode (start_mode),
        .start_seed (start_seed),
        .start_qlen (start_qlen),
        .ref_valid  (ref_valid),
        .ref_sym    (ref_sym),
        .ref_last   (ref_last),
        .ref_ready  (ref_ready),
        .load       (load),
        .mode_local (mode_local),
        .qlen       (qlen),
        .pe0_valid  (ch_valid[0]),
        .pe0_sym    (ch_sym[0]),
        .pe0_row    (ch_row[0]),
        .pe0_left   (ch_h[0]),
        .pe0_diag   (ch_hdiag[0]),
        .fin        (fin)
    );

    for (genvar i = 0; i < NUM_PE; i++) begin : g_pe
        logic signed [SW-1:0] top_init;
        assign top_init = start_mode
                        ? SW'(sxa_clamp(int'(start_seed) - GAP * (i + 1), SW))
                        : '0;

        sxa_pe #(
            .SW       (SW),
            .ROW_W    (ROW_W),
            .MATCH    (MATCH),
            .MISMATCH (MISMATCH),
            .GAP      (GAP)
        ) u_pe (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (load),
            .load_sym   (query_syms[2*i +: 2]),
            .load_top   (top_init),
            .mode_local (mode_local),
            .in_valid   (ch_valid[i]),
            .in_sym     (ch_sym[i]),
            .in_row     (ch_row[i]),
            .in_left    (ch_h[i]),
            .in_diag    (ch_hdiag[i]),
            .out_valid  (ch_valid[i+1]),
            .out_sym    (ch_sym[i+1]),
            .out_row    (ch_row[i+1]),
            .out_h      (ch_h[i+1]),
            .out_hdiag  (ch_hdiag[i+1]),
            .best_score (pe_best[i]),
            .best_row   (pe_brow[i])
        );

        AST_FLOW: assert property (@(posedge clk) disable iff (!rst_n)
            ch_valid[i] |=> (ch_valid[i+1] && ch_row[i+1] == $past(ch_row[i])
                             && ch_sym[i+1] == $past(ch_sym[i]))); // R8

        AST_LOCAL_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_valid[i+1] && mode_local) |-> (!ch_h[i+1][SW-1] && !ch_hdiag[i+1][SW-1])); // R2
    end

    sxa_pick #(
        .NUM_PE (NUM_PE),
        .SW     (SW),
        .ROW_W  (ROW_W)
    ) u_pick (
        .pe_best   (pe_best),
        .pe_brow   (pe_brow),
        .qlen      (qlen),
        .sel_score (pk_score),
        .sel_row   (pk_row),
        .sel_col   (pk_col),
        .end_score (pk_escore),
        .end_row   (pk_erow),
        .end_col   (pk_ecol)
    );

    typedef struct packed {
        logic                 done;
        logic signed [SW-1:0] bscore;
        logic [ROW_W-1:0]     brow;
        logic [COL_W-1:0]     bcol;
        logic signed [SW-1:0] escore;
        logic [ROW_W-1:0]     erow;
        logic [COL_W-1:0]     ecol;
    } res_s;

    res_s res_d, res_q;

    always_comb begin : res_next
        res_d      = res_q;
        res_d.done = fin;
        if (fin) begin
            res_d.bscore = pk_score;
            res_d.brow   = pk_row;
            res_d.bcol   = pk_col;
            res_d.escore = pk_escore;
            res_d.erow   = pk_erow;
            res_d.ecol   = pk_ecol;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign done       = res_q.done;
    assign best_score = res_q.bscore;
    assign best_row   = res_q.brow;
    assign best_col   = res_q.bcol;
    assign end_score  = res_q.escore;
    assign end_row    = res_q.erow;
    assign end_col    = res_q.ecol;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_END_LE_BEST: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (end_score <= best_score)); // R7

endmodule

// File: tb/test_seed_ext_array.sv
module test_seed_ext_array;

    localparam int CLK_PERIOD = 10;
    localparam int NPE     = 16;
    localparam int TSW     = 16;
    localparam int TROW    = 16;
    localparam int TMATCH  = 2;
    localparam int TMIS    = -1;
    localparam int TGAP    = 1;
    localparam int QW      = $clog2(NPE + 1);
    localparam int CW      = $clog2(NPE);
    localparam int MAXR    = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic start_mode = 1'b0;
    logic signed [TSW-1:0] start_seed = '0;
    logic [QW-1:0] start_qlen = '0;
    logic [2*NPE-1:0] query_syms = '0;
    logic ref_valid = 1'b0;
    logic ref_ready;
    logic [1:0] ref_sym = '0;
    logic ref_last = 1'b0;
    logic done;
    logic signed [TSW-1:0] best_score;
    logic [TROW-1:0] best_row;
    logic [CW-1:0] best_col;
    logic signed [TSW-1:0] end_score;
    logic [TROW-1:0] end_row;
    logic [CW-1:0] end_col;

    always #(CLK_PERIOD / 2) clk = ~clk;

    seed_ext_array #(
        .NUM_PE(NPE), .SW(TSW), .ROW_W(TROW),
        .MATCH(TMATCH), .MISMATCH(TMIS), .GAP(TGAP)
    ) i_seed_ext_array (
        .clk(clk), .rst_n(rst_n), .start(start), .start_mode(start_mode),
        .start_seed(start_seed), .start_qlen(start_qlen), .query_syms(query_syms),
        .ref_valid(ref_valid), .ref_ready(ref_ready), .ref_sym(ref_sym),
        .ref_last(ref_last), .done(done), .best_score(best_score),
        .best_row(best_row), .best_col(best_col), .end_score(end_score),
        .end_row(end_row), .end_col(end_col)
    );

    int total = 0;
    int bad = 0;
    int qa[NPE];
    int ra[MAXR];
    int hm[MAXR][NPE];
    int e_bs, e_br, e_bc, e_es, e_er, e_ec;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int sat(input int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    // Cycle model of handshake and done timing, advanced on every rising edge.
    bit exp_run = 0, exp_idle = 1, exp_done = 0;
    int since = -1;

    always @(posedge clk) begin
        if (!rst_n) begin
            exp_run = 0; exp_idle = 1; exp_done = 0; since = -1;
        end else begin
            exp_done = 0;
            if (exp_idle && start) begin
                exp_idle = 0; exp_run = 1;
            end else if (exp_run && ref_valid && ref_last) begin
                exp_run = 0; since = 0;
            end else if (since >= 0) begin
                since++;
                if (since == NPE) begin
                    exp_done = 1; exp_idle = 1; since = -1;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk(ref_ready == exp_run, "R9 ref_ready", int'(ref_ready), int'(exp_run));
            chk(done == exp_done, "R8 done timing", int'(done), int'(exp_done));
            if (exp_done) begin
                chk(int'(best_score) == e_bs, "R6 best_score", int'(best_score), e_bs);
                chk(int'(best_row) == e_br, "R6 best_row", int'(best_row), e_br);
                chk(int'(best_col) == e_bc, "R6 best_col", int'(best_col), e_bc);
                chk(int'(end_score) == e_es, "R7 end_score", int'(end_score), e_es);
                chk(int'(end_row) == e_er, "R7 end_row", int'(end_row), e_er);
                chk(int'(end_col) == e_ec, "R7 end_col", int'(end_col), e_ec);
            end
        end
    end

    // Matrix model: R2, R3, R4, R5 border and recurrence; R6, R7 selection.
    task automatic model(input bit ext, input int seed, input int qlen, input int rlen);
        int dg, lf, up, m, first;
        for (int r = 0; r < rlen; r++) begin
            for (int c = 0; c < NPE; c++) begin
                int tb_c, tb_cm1, lb_r, lb_rm1;
                tb_c   = ext ? sat(seed - TGAP * (c + 1)) : 0;
                tb_cm1 = ext ? sat(seed - TGAP * c) : 0;
                lb_r   = ext ? sat(seed - TGAP * (r + 1)) : 0;
                lb_rm1 = ext ? sat(seed - TGAP * r) : 0;
                if (r == 0) dg = (c == 0) ? (ext ? seed : 0) : tb_cm1;
                else        dg = (c == 0) ? lb_rm1 : hm[r-1][c-1];
                lf = (c == 0) ? lb_r : hm[r][c-1];
                up = (r == 0) ? tb_c : hm[r-1][c];
                m = dg + ((ra[r] == qa[c]) ? TMATCH : TMIS);
                if (lf - TGAP > m) m = lf - TGAP;
                if (up - TGAP > m) m = up - TGAP;
                if (!ext && m < 0) m = 0;
                hm[r][c] = sat(m);
            end
        end
        first = 1;
        for (int c = 0; c < qlen; c++)
            for (int r = 0; r < rlen; r++)
                if (first == 1 || hm[r][c] > e_bs) begin
                    first = 0; e_bs = hm[r][c]; e_br = r; e_bc = c;
                end
        e_ec = qlen - 1; e_es = hm[0][e_ec]; e_er = 0;
        for (int r = 1; r < rlen; r++)
            if (hm[r][e_ec] > e_es) begin e_es = hm[r][e_ec]; e_er = r; end
    endtask

    task automatic run_job(input bit ext, input int seed, input int qlen,
                           input int rlen, input bit gaps, input bit poke);
        model(ext, seed, qlen, rlen);
        @(negedge clk);
        start = 1'b1; start_mode = ext; start_seed = TSW'(seed);
        start_qlen = QW'(qlen);
        for (int c = 0; c < NPE; c++) query_syms[2*c +: 2] = 2'(qa[c]);
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < rlen; k++) begin
            if (gaps && (k % 3 == 1)) begin
                ref_valid = 1'b0;
                @(negedge clk);
            end
            ref_valid = 1'b1; ref_sym = 2'(ra[k]); ref_last = (k == rlen - 1);
            if (poke && k == 1) begin
                // R1: a launch attempt mid-job must change nothing
                start = 1'b1; start_mode = !ext; start_seed = 16'sd999; start_qlen = QW'(1);
            end
            while (!ref_ready) @(negedge clk);
            @(negedge clk);
            start = 1'b0;
        end
        ref_valid = 1'b0; ref_last = 1'b0;
        for (int w = 0; w < NPE + 4 && !done; w++) @(negedge clk);
        chk(done == 1'b1, "R8 done seen", int'(done), 1);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R8 reset done", int'(done), 0);
        chk(ref_ready == 1'b0, "R9 reset ready", int'(ref_ready), 0);
        chk(best_score == '0, "R6 reset best", int'(best_score), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: symbols offered while idle are ignored
        ref_valid = 1'b1; ref_last = 1'b1; ref_sym = 2'd3;
        repeat (3) @(negedge clk);
        chk(ref_ready == 1'b0, "R9 idle ignore", int'(ref_ready), 0);
        chk(done == 1'b0, "R9 idle no done", int'(done), 0);
        ref_valid = 1'b0; ref_last = 1'b0;

        // Worked example, query GCAA (G=2,C=1,A=0) vs reference AGCA, R10 packing
        for (int c = 0; c < NPE; c++) qa[c] = 3;
        qa[0] = 2; qa[1] = 1; qa[2] = 0; qa[3] = 0;
        ra[0] = 0; ra[1] = 2; ra[2] = 1; ra[3] = 0;
        run_job(1'b0, 0, 4, 4, 1'b0, 1'b0);
        chk(int'(best_score) == 6, "R2 R4 R10 local best", int'(best_score), 6);
        chk(int'(best_col) == 2, "R10 local best col", int'(best_col), 2);
        chk(int'(end_score) == 5, "R7 local end", int'(end_score), 5);
        run_job(1'b1, 50, 4, 4, 1'b1, 1'b0);
        chk(int'(best_score) == 55, "R3 ext best", int'(best_score), 55);
        chk(int'(end_score) == 54, "R3 R7 ext end", int'(end_score), 54);
        chk(int'(end_row) == 3, "R7 ext end row", int'(end_row), 3);
        repeat (2) @(negedge clk);
        chk(int'(best_score) == 55, "R8 result held", int'(best_score), 55);

        // R5: saturation at both ends
        for (int c = 0; c < NPE; c++) qa[c] = 0;
        for (int r = 0; r < 12; r++) ra[r] = 0;
        run_job(1'b1, 32760, NPE, 12, 1'b0, 1'b0);
        chk(int'(best_score) == 32767, "R5 top clamp", int'(best_score), 32767);
        for (int r = 0; r < 6; r++) ra[r] = 1;
        run_job(1'b1, -32768, NPE, 6, 1'b0, 1'b0);
        chk(int'(best_score) == -32768, "R5 bottom clamp", int'(best_score), -32768);

        // Boundary query lengths: single column and full array
        for (int c = 0; c < NPE; c++) qa[c] = c % 4;
        for (int r = 0; r < 20; r++) ra[r] = (r * 3) % 4;
        run_job(1'b0, 0, 1, 20, 1'b0, 1'b0);
        run_job(1'b0, 0, NPE, 20, 1'b1, 1'b1);
        run_job(1'b1, 10, 1, 1, 1'b0, 1'b0);

        // Randomised jobs, including mid-job launch attempts (R1)
        for (int j = 0; j < 40; j++) begin
            int ql, rl;
            ql = $urandom_range(1, NPE);
            rl = $urandom_range(1, 24);
            for (int c = 0; c < NPE; c++) qa[c] = $urandom_range(0, 3);
            for (int r = 0; r < rl; r++) ra[r] = $urandom_range(0, 3);
            run_job(1'($urandom_range(0, 1)), $urandom_range(0, 200) - 100, ql, rl,
                    1'($urandom_range(0, 1)), (j % 5 == 0) && (rl >= 2));
        end

        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule